// File: doc/BRIEF.md
# Multi-Tap Fractional Spreading-Code Resampler

This block produces several delayed replicas of a binary spreading code at the rate of incoming samples, as needed by a tracking correlator that compares early, on-time and late versions of the local code with the received signal. The chips come from a small on-chip code memory. Software loads that memory one chip per write through a single streaming port. Before each load it sends a command word that returns the internal write pointer to zero. When the pilot option is used, a second code for the data component goes into a second memory through the same port, and one more replica tap reads from it.

Each tap keeps its own integer chip index and its own 20-bit fractional chip counter. One whole chip is 2^20 counts. All taps advance by one shared step, given in the same fractional units. That step can ramp: a signed rate is added to it after every valid sample. A carry out of a tap's fractional counter moves that tap's index forward by one chip. The index wraps to zero after the programmed last chip, which software writes as length minus one. A start pulse loads every tap's initial index and fraction, and the shared step, in the same cycle. From then on, every tap shows its current chip as a signed ±1 value.

Top module: `code_tap_resampler`

## Requirements
- R1: While reset is applied and after its release, before any start pulse, every tap output is 0 (2'b00) and `smp_out_vld` is 0.
- R2: A fill write with `fill_word[1]`=1 is a command. It resets the write pointer of the memory chosen by `fill_sel` to 0 and stores nothing. A fill write with `fill_word[1]`=0 stores `fill_word[0]` at the pointer of the chosen memory, then increments that pointer. `fill_sel`=0 selects the primary code memory and `fill_sel`=1 selects the data code memory.
- R3: A start pulse loads every tap's initial index and fraction, and the shared step, in one cycle. If `smp_vld` is high in the same cycle, the start takes priority and no tap advances in that cycle.
- R4: In each cycle with `smp_vld` high after start, each tap adds the current step to its 20-bit fraction. A carry out of the fraction advances that tap's index by one.
- R5: A tap whose index equals `code_len_m1` and whose fraction carries moves to index 0.
- R6: The first sample after start uses the programmed step. After every valid sample the step changes by the signed `step_rate`, modulo 2^20.
- R7: In cycles with `smp_vld` low, no tap index, tap fraction or step changes.
- R8: Tap i occupies bits [2i+1:2i] of `tap_pm`. After start it shows +1 (2'b01) when the chip at its current index is 1, and -1 (2'b11) when that chip is 0. Taps 0 to NTAPS-1 read the primary memory.
- R9: The extra tap, at index NTAPS, reads the data memory. Its output is 0 whenever `pilot_en` is 0.
- R10: A chip written while the taps run appears on a tap that sits at the written address from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_we | input | 1 | Fill port write strobe |
| fill_sel | input | 1 | Target memory: 0 primary, 1 data |
| fill_word | input | 2 | Bit 1 = pointer-reset command, bit 0 = chip value |
| code_len_m1 | input | IDX_W | Code length minus one |
| pilot_en | input | 1 | Enables the data-code tap |
| init_idx | input | (NTAPS+1)*IDX_W | Initial chip index per tap, tap i at [i*IDX_W +: IDX_W] |
| init_frac | input | (NTAPS+1)*FRAC_W | Initial fraction per tap, tap i at [i*FRAC_W +: FRAC_W] |
| step_init | input | FRAC_W | Code step per sample, in units of 2^-20 chip |
| step_rate | input | FRAC_W | Signed change of step per sample |
| start | input | 1 | Load pulse for all taps |
| smp_vld | input | 1 | Sample-valid strobe |
| smp_out_vld | output | 1 | Running and current sample valid |
| tap_pm | output | 2*(NTAPS+1) | Signed ±1 chip per tap, 0 when idle |

## Verification
Two pairs of events can fall in the same cycle. A start pulse can arrive together with a sample strobe, and a memory write can arrive while the taps are reading. The bench drives start with `smp_vld` high and expects every tap to show the chip at its initial index, not the chip one step further on. It also freezes the taps, rewrites the chip under tap 0, and expects the old chip in the write cycle and the new chip in the cycle after it. Randomised runs with ramping steps and random sample gaps are then checked on every cycle against a reference model in the bench.

// File: rtl/cres_pkg.sv
package cres_pkg;
  typedef logic signed [1:0] pm_t;

  localparam pm_t PM_POS = 2'sb01;
  localparam pm_t PM_NEG = 2'sb11;
  localparam pm_t PM_OFF = 2'sb00;

  function automatic pm_t chip_to_pm(input logic chip);
    return chip ? PM_POS : PM_NEG;
  endfunction
endpackage

// File: rtl/cres_code_ram.sv
module cres_code_ram #(
  parameter int IDX_W = 10,
  parameter int NRD   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_hit,
  input  logic [1:0]         wr_word,
  input  logic [NRD*IDX_W-1:0] rd_addr,
  output logic [NRD-1:0]     rd_chip
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] mem_q;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic             cmd_clr, do_store;

  assign cmd_clr  = wr_hit & wr_word[1];
  assign do_store = wr_hit & ~wr_word[1];

  always_comb begin
    ptr_d = ptr_q;
    if (cmd_clr)       ptr_d = '0;
    else if (do_store) ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  always_ff @(posedge clk) begin
    if (do_store) mem_q[ptr_q] <= wr_word[0];
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_chip[r] = mem_q[rd_addr[r*IDX_W +: IDX_W]];
  end

  p_ptr_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clr |=> ptr_q == '0);
  p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    do_store |=> ptr_q == $past(ptr_q) + 1'b1);
  p_ptr_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(ptr_q));
endmodule

// File: rtl/cres_step_ramp.sv
module cres_step_ramp #(
  parameter int FRAC_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic [FRAC_W-1:0] step_init,
  input  logic [FRAC_W-1:0] step_rate,
  output logic [FRAC_W-1:0] step_cur
);
  logic [FRAC_W-1:0] step_q, step_d;

  always_comb begin
    step_d = step_q;
    if (load)     step_d = step_init;
    else if (adv) step_d = step_q + step_rate;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= '0;
    else        step_q <= step_d;
  end

  assign step_cur = step_q;

  p_ramp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> step_q == $past(step_q) + $past(step_rate));
  p_step_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !load) |=> $stable(step_q));
endmodule

// File: rtl/cres_tap_ctr.sv
module cres_tap_ctr #(
  parameter int IDX_W  = 10,
  parameter int FRAC_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic [IDX_W-1:0]  idx_init,
  input  logic [FRAC_W-1:0] frac_init,
  input  logic [IDX_W-1:0]  len_m1,
  input  logic [FRAC_W-1:0] step,
  output logic [IDX_W-1:0]  idx
);
  logic [IDX_W-1:0]  idx_q, idx_d, idx_inc;
  logic [FRAC_W-1:0] frac_q, frac_d;
  logic [FRAC_W:0]   sum;
  logic              carry;

  assign sum     = {1'b0, frac_q} + {1'b0, step};
  assign carry   = sum[FRAC_W];
  assign idx_inc = (idx_q == len_m1) ? '0 : idx_q + 1'b1;

  always_comb begin
    idx_d  = idx_q;
    frac_d = frac_q;
    if (load) begin
      idx_d  = idx_init;
      frac_d = frac_init;
    end else if (adv) begin
      frac_d = sum[FRAC_W-1:0];
      if (carry) idx_d = idx_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      frac_q <= '0;
    end else begin
      idx_q  <= idx_d;
      frac_q <= frac_d;
    end
  end

  assign idx = idx_q;

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (idx_q == $past(idx_init)) && (frac_q == $past(frac_init)));
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && carry && idx_q == len_m1) |=> idx_q == '0);
  p_nocarry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && !carry) |=> $stable(idx_q));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !load) |=> $stable(idx_q) && $stable(frac_q));
endmodule

// File: rtl/code_tap_resampler.sv
module code_tap_resampler
  import cres_pkg::*;
#(
  parameter int NTAPS  = 3,
  parameter int IDX_W  = 10,
  parameter int FRAC_W = 20
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          fill_we,
  input  logic                          fill_sel,
  input  logic [1:0]                    fill_word,
  input  logic [IDX_W-1:0]              code_len_m1,
  input  logic                          pilot_en,
  input  logic [(NTAPS+1)*IDX_W-1:0]    init_idx,
  input  logic [(NTAPS+1)*FRAC_W-1:0]   init_frac,
  input  logic [FRAC_W-1:0]             step_init,
  input  logic [FRAC_W-1:0]             step_rate,
  input  logic                          start,
  input  logic                          smp_vld,
  output logic                          smp_out_vld,
  output logic [2*(NTAPS+1)-1:0]        tap_pm
);
  localparam int NALL = NTAPS + 1;

  logic                    run_q, run_d, adv;
  logic [FRAC_W-1:0]       step_cur;
  logic [NALL*IDX_W-1:0]   tap_idx;
  logic [NTAPS-1:0]        prim_chip;
  logic [0:0]              data_chip;

  assign run_d = run_q | start;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_d;
  end

  assign adv         = run_q & smp_vld & ~start;
  assign smp_out_vld = run_q & smp_vld;

  cres_step_ramp #(.FRAC_W(FRAC_W)) u_ramp (
    .clk(clk), .rst_n(rst_n), .load(start), .adv(adv),
    .step_init(step_init), .step_rate(step_rate), .step_cur(step_cur)
  );

  for (genvar t = 0; t < NALL; t++) begin : g_tap
    cres_tap_ctr #(.IDX_W(IDX_W), .FRAC_W(FRAC_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .load(start), .adv(adv),
      .idx_init(init_idx[t*IDX_W +: IDX_W]),
      .frac_init(init_frac[t*FRAC_W +: FRAC_W]),
      .len_m1(code_len_m1), .step(step_cur),
      .idx(tap_idx[t*IDX_W +: IDX_W])
    );
  end

  cres_code_ram #(.IDX_W(IDX_W), .NRD(NTAPS)) u_prim (
    .clk(clk), .rst_n(rst_n),
    .wr_hit(fill_we & ~fill_sel), .wr_word(fill_word),
    .rd_addr(tap_idx[NTAPS*IDX_W-1:0]), .rd_chip(prim_chip)
  );

  cres_code_ram #(.IDX_W(IDX_W), .NRD(1)) u_data (
    .clk(clk), .rst_n(rst_n),
    .wr_hit(fill_we & fill_sel), .wr_word(fill_word),
    .rd_addr(tap_idx[NALL*IDX_W-1 -: IDX_W]), .rd_chip(data_chip)
  );

  for (genvar t = 0; t < NTAPS; t++) begin : g_out
    assign tap_pm[2*t +: 2] = run_q ? chip_to_pm(prim_chip[t]) : PM_OFF;
  end
  assign tap_pm[2*NTAPS +: 2] = (run_q && pilot_en) ? chip_to_pm(data_chip[0]) : PM_OFF;

  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (tap_pm == '0) && !smp_out_vld);
  p_pilot_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pilot_en |-> tap_pm[2*NTAPS +: 2] == 2'b00);
  p_run_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> run_q);
  p_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> tap_pm[1:0] != 2'b00 && tap_pm[1:0] != 2'b10);
endmodule

// File: tb/code_tap_resampler_test.sv
module code_tap_resampler_test;
  localparam int CLK_NS = 10;
  localparam int NT     = 3;
  localparam int NA     = NT + 1;
  localparam int IW     = 10;
  localparam int FW     = 20;
  localparam int DEPTH  = 1 << IW;
  localparam longint FMASK = (64'd1 << FW) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic fill_we, fill_sel;
  logic [1:0] fill_word;
  logic [IW-1:0] code_len_m1;
  logic pilot_en;
  logic [NA*IW-1:0] init_idx;
  logic [NA*FW-1:0] init_frac;
  logic [FW-1:0] step_init, step_rate;
  logic start, smp_vld;
  logic smp_out_vld;
  logic [2*NA-1:0] tap_pm;

  always #(CLK_NS/2) clk = ~clk;

  code_tap_resampler #(.NTAPS(NT), .IDX_W(IW), .FRAC_W(FW)) uut (
    .clk(clk), .rst_n(rst_n), .fill_we(fill_we), .fill_sel(fill_sel),
    .fill_word(fill_word), .code_len_m1(code_len_m1), .pilot_en(pilot_en),
    .init_idx(init_idx), .init_frac(init_frac), .step_init(step_init),
    .step_rate(step_rate), .start(start), .smp_vld(smp_vld),
    .smp_out_vld(smp_out_vld), .tap_pm(tap_pm)
  );

  int nchk = 0, nerr = 0;
  bit m_mem [0:1][0:DEPTH-1];
  int m_ptr [0:1];
  int m_idx [0:NA-1];
  longint m_frac [0:NA-1];
  longint m_step;
  bit m_run;

  function automatic logic [2*NA-1:0] exp_vec();
    logic [2*NA-1:0] v = '0;
    for (int t = 0; t < NA; t++) begin
      bit on = m_run && (t < NT || pilot_en);
      bit c  = (t < NT) ? m_mem[0][m_idx[t]] : m_mem[1][m_idx[t]];
      v[2*t +: 2] = on ? (c ? 2'b01 : 2'b11) : 2'b00;
    end
    return v;
  endfunction

  task automatic check(input string req);
    logic [2*NA-1:0] e = exp_vec();
    nchk++;
    if (tap_pm !== e) begin
      nerr++;
      $display("FAIL %s tap_pm=%b expected=%b", req, tap_pm, e);
    end
  endtask

  task automatic model_edge(input bit st, input bit sv, input bit fwe, input bit [1:0] fw, input bit fs);
    if (fwe) begin
      if (fw[1]) m_ptr[fs] = 0;
      else begin
        m_mem[fs][m_ptr[fs]] = fw[0];
        m_ptr[fs] = (m_ptr[fs] + 1) % DEPTH;
      end
    end
    if (st) begin
      m_run = 1;
      for (int t = 0; t < NA; t++) begin
        m_idx[t]  = int'(init_idx[t*IW +: IW]);
        m_frac[t] = longint'(init_frac[t*FW +: FW]);
      end
      m_step = longint'(step_init);
    end else if (m_run && sv) begin
      for (int t = 0; t < NA; t++) begin
        longint s = m_frac[t] + m_step;
        m_frac[t] = s & FMASK;
        if (s > FMASK) m_idx[t] = (m_idx[t] == int'(code_len_m1)) ? 0 : m_idx[t] + 1;
      end
      m_step = (m_step + longint'(step_rate)) & FMASK;
    end
  endtask

  // Called just after a falling edge: drive, pass one rising edge, return at the next falling edge.
  task automatic cyc(input bit st, input bit sv, input bit fwe, input bit [1:0] fw, input bit fs);
    start = st; smp_vld = sv; fill_we = fwe; fill_word = fw; fill_sel = fs;
    model_edge(st, sv, fwe, fw, fs);
    @(posedge clk);
    @(negedge clk);
    start = 0; smp_vld = 0; fill_we = 0;
  endtask

  task automatic fill_code(input bit sel, input int len);
    cyc(0, 0, 1, 2'b10, sel);
    for (int k = 0; k < len; k++) cyc(0, 0, 1, {1'b0, 1'($urandom)}, sel);
  endtask

  task automatic set_taps(input int len);
    for (int t = 0; t < NA; t++) begin
      init_idx[t*IW +: IW]  = IW'($urandom % len);
      init_frac[t*FW +: FW] = FW'($urandom);
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    m_run = 0; m_ptr[0] = 0; m_ptr[1] = 0; m_step = 0;
    for (int t = 0; t < NA; t++) begin m_idx[t] = 0; m_frac[t] = 0; end
    for (int s = 0; s < 2; s++) for (int a = 0; a < DEPTH; a++) m_mem[s][a] = 0;
    rst_n = 0; start = 0; smp_vld = 0; fill_we = 0; fill_sel = 0; fill_word = 0;
    pilot_en = 1; code_len_m1 = 39; init_idx = '0; init_frac = '0;
    step_init = '0; step_rate = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1;
    @(negedge clk);
    smp_vld = 1; #1;
    nchk++;
    if (smp_out_vld !== 1'b0) begin nerr++; $display("FAIL R1 smp_out_vld=%b expected=0", smp_out_vld); end
    smp_vld = 0;
    @(negedge clk);
    check("R1 after release");

    // R2: fill both memories, clear command before each fill
    for (int a = 0; a < DEPTH; a++) begin m_mem[0][a] = 0; m_mem[1][a] = 0; end
    fill_code(0, 40);
    fill_code(1, 40);
    // R2/R8: frozen taps at fixed addresses show stored chips
    for (int t = 0; t < NA; t++) begin
      init_idx[t*IW +: IW] = IW'(t * 5);
      init_frac[t*FW +: FW] = '0;
    end
    cyc(1, 0, 0, 2'b00, 0);
    check("R2 R8 R9 chip readback after fill");
    for (int a = 0; a < 8; a++) begin
      init_idx = {IW'(a + 8), IW'(a + 16), IW'(a + 24), IW'(a)};
      cyc(1, 0, 0, 2'b00, 0);
      check("R2 R8 sweep");
    end

    // R3: start and sample valid together -> no advance
    step_init = FW'(20'hFFFFF); step_rate = '0;
    set_taps(40);
    cyc(1, 1, 0, 2'b00, 0);
    check("R3 start wins over smp_vld");
    cyc(0, 1, 0, 2'b00, 0);
    check("R4 first sample after start");

    // R5: wrap at last chip
    for (int t = 0; t < NA; t++) begin
      init_idx[t*IW +: IW] = code_len_m1;
      init_frac[t*FW +: FW] = FW'(20'hFFFFF);
    end
    step_init = FW'(1);
    cyc(1, 0, 0, 2'b00, 0);
    check("R5 at last chip");
    cyc(0, 1, 0, 2'b00, 0);
    check("R5 wrapped to chip 0");
    nchk++;
    if (m_idx[0] != 0) begin nerr++; $display("FAIL R5 model idx=%0d expected=0", m_idx[0]); end

    // R7: no valid -> frozen
    step_init = FW'(20'h80000);
    set_taps(40);
    cyc(1, 0, 0, 2'b00, 0);
    for (int k = 0; k < 6; k++) begin
      cyc(0, 0, 0, 2'b00, 0);
      check("R7 hold without smp_vld");
    end

    // R10: rewrite chip under tap 0 while running (taps frozen at idx 0)
    init_idx = '0; init_frac = '0;
    cyc(1, 0, 0, 2'b00, 0);
    cyc(0, 0, 1, 2'b10, 0);
    begin
      bit nv = ~m_mem[0][0];
      start = 0; smp_vld = 0; fill_we = 1; fill_word = {1'b0, nv}; fill_sel = 0;
      #1;
      check("R10 old chip during write cycle");
      model_edge(0, 0, 1, {1'b0, nv}, 0);
      @(posedge clk); @(negedge clk);
      fill_we = 0;
      check("R10 new chip after write");
    end

    // R9: pilot off, extra tap silent
    pilot_en = 0;
    cyc(0, 1, 0, 2'b00, 0);
    check("R9 pilot disabled");

    // R4/R6/R9: randomised runs
    for (int run = 0; run < 6; run++) begin
      int len = 16 + int'($urandom % 48);
      longint r;
      code_len_m1 = IW'(len - 1);
      pilot_en = run[0];
      fill_code(0, len);
      fill_code(1, len);
      set_taps(len);
      step_init = FW'(20'h40000 + ($urandom % 20'h80000));
      r = longint'($urandom % 801) - 400;
      step_rate = FW'(r & FMASK);
      cyc(1, 1, 0, 2'b00, 0);
      check("R3 random start");
      for (int k = 0; k < 400; k++) begin
        cyc(0, ($urandom % 4) != 0, 0, 2'b00, 0);
        check("R4 R6 random run");
      end
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule